// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire PHY management bus. It generates the management clock and the serial data line. Software first loads a target word that holds the PHY address and the register number. To write, software stores a 16-bit value in the data-out register, and that store launches a write frame. To read, software clears the read-request bit and then sets it again. The rising edge of that bit launches a read frame. The result is placed in a read-data register. A status word shows whether a frame is in flight and whether fresh read data is still pending.

Frames follow the clause-22 layout:
- 32 preamble ones.
- Start code `01`.
- Opcode `01` for a write or `10` for a read.
- 5-bit PHY address, then 5-bit register number.
- Two turnaround bits.
- 16 data bits, most significant bit first.

The master changes the data line while the management clock is low. On reads it releases the line from the first turnaround bit to the end of the frame, and it samples the PHY's bits on each rising clock edge. A configuration write with its top bit set aborts any frame and clears the interface.

The host side is a simple 32-bit write strobe with a combinational read port. Word offsets are:
- 0x00: clock setup
- 0x04: read request
- 0x08: target
- 0x0C: data out
- 0x10: read data
- 0x14: status

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset:
  - the clock setup word reads 7;
  - status, read data, target, data out and read request all read 0;
  - the management clock is low and the data line is not driven (`mdio_oe` = 0).
- R2: The target word at 0x08 keeps the PHY address in bits 12:8 and the register number in bits 4:0. All other bits read back as 0.
- R3: A host write to 0x0C while idle starts a write frame. The frame carries 32 ones, `01`, `01`, the PHY address, the register number, turnaround `10` and bits 15:0 of the written word, most significant bit first. Every bit is driven and stable at the rising clock edge.
- R4: A read frame starts only when bit 0 of the read-request word at 0x04 is written as 1 while its stored value is 0. Writing 1 when it already holds 1 starts nothing.
- R5: A read frame uses opcode `10`. The master holds `mdio_oe` low for frame bits 46 to 63 (turnaround plus data). It samples `mdio_i` at the 16 rising clock edges of the data bits. It places the result in bits 15:0 of the read-data word at 0x10.
- R6: Status bit 0 (busy, at 0x14) goes to 1 in the clock cycle after the launching write. It stays 1 for exactly 128·H system clock cycles, where H is the half-period defined in R8.
- R7: Status bit 2 (data pending) is set by a read launch. It is cleared at the same edge that ends that read's busy period, when the read data is captured.
- R8: With `S` = clock setup bits 2:0, each half-period of the management clock lasts H = 10 + 2·S system clock cycles. This keeps the management clock at or below 2.5 MHz on a 50 MHz system clock.
- R9: While busy, host writes to the clock setup (without bit 31), read-request, target and data-out words are ignored. Their values are unchanged and the running frame is neither restarted nor altered.
- R10: A write to 0x00 with bit 31 set ends any frame. From the next cycle busy and data pending are 0, the clock is low and the line is released. Read request, target, data out and read data are cleared, and the clock setup takes bits 2:0 of that word.
- R11: The management clock rises exactly 64 times per frame and stays low whenever no frame is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Host write strobe, sampled on the rising clock edge |
| bus_addr | input | 5 | Host byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven onto the line |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
A launching write is sampled at one clock edge, and busy and data pending are visible after that edge. Busy must remain 1 at the 128·H−1th cycle after that edge and must be 0 at the 128·H-th. The bench checks status at exactly those two points, counting cycles from the launch, for every divider setting it uses. Captured frame bits and drive-enable patterns are taken one nanosecond after each rising management-clock edge, which is when the PHY would sample. Register read-back and abort effects are checked on the falling system clock edge right after the cycle that makes them due.

// File: rtl/mdio_pkg.sv
// Package: shared constants for the management master.
// Assumes word-aligned host accesses; address bits 1:0 are ignored.
package mdio_pkg;
    localparam int unsigned HOST_AW    = 5;
    localparam int unsigned WIDX_W     = HOST_AW - 2;
    localparam int unsigned DATA_W     = 16;
    localparam int unsigned FIELD_W    = 5;
    localparam int unsigned SEL_W      = 3;
    localparam int unsigned FRAME_BITS = 64;
    localparam int unsigned CNT_BITS_W = $clog2(FRAME_BITS);

    localparam logic [CNT_BITS_W-1:0] LAST_BIT   = CNT_BITS_W'(FRAME_BITS - 1);
    localparam logic [CNT_BITS_W-1:0] REL_FIRST  = CNT_BITS_W'(46);
    localparam logic [CNT_BITS_W-1:0] DATA_FIRST = CNT_BITS_W'(48);

    localparam logic [WIDX_W-1:0] W_SETUP = WIDX_W'(0);
    localparam logic [WIDX_W-1:0] W_RDREQ = WIDX_W'(1);
    localparam logic [WIDX_W-1:0] W_TARGET = WIDX_W'(2);
    localparam logic [WIDX_W-1:0] W_DOUT  = WIDX_W'(3);
    localparam logic [WIDX_W-1:0] W_DIN   = WIDX_W'(4);
    localparam logic [WIDX_W-1:0] W_STAT  = WIDX_W'(5);

    typedef struct packed {
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regn;
    } target_t;
endpackage

// File: rtl/mdio_clk_div.sv
// Half-period timer: pulses tick on the last system cycle of each
// management-clock half-period. Length is MIN_HALF + STEP*sel cycles.
// Assumes sel is held stable while run is high.
module mdio_clk_div #(
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned MIN_HALF = 10,
    parameter int unsigned STEP     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned MAX_HALF = MIN_HALF + STEP * ((1 << SEL_W) - 1);
    localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Last count value of the selected half-period.
    always_comb begin
        last = CNT_W'(MIN_HALF - 1) + CNT_W'(STEP) * CNT_W'(sel);
    end

    // Count cycles within a half-period; hold at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == last);
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: serialises one 64-bit clause-22 frame per start, one bit
// per management-clock period. Data changes while mdc is low; on reads the
// line is released from bit 46 and data is sampled at each rising edge.
// Assumes start is only raised while idle; abort wins over start.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic              abort,
    input  target_t           tgt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic              mdio_i,
    output logic              running,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic                  run_q;
    logic                  rd_q;
    logic                  phase_q;
    logic [CNT_BITS_W-1:0] bit_q;
    logic [31:0]           hdr_q;
    logic [DATA_W-1:0]     rx_q;
    logic [31:0]           hdr_next;

    // Post-preamble half of the frame for the requested operation.
    always_comb begin
        hdr_next = {2'b01, (start_rd ? 2'b10 : 2'b01), tgt.phy, tgt.regn,
                    2'b10, wdata};
    end

    // Sequencer: bit counter and clock phase, advanced on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            run_q   <= 1'b0;
            rd_q    <= 1'b0;
            phase_q <= 1'b0;
            bit_q   <= '0;
            hdr_q   <= '0;
        end else if (start && !run_q) begin
            run_q   <= 1'b1;
            rd_q    <= start_rd;
            phase_q <= 1'b0;
            bit_q   <= '0;
            hdr_q   <= hdr_next;
        end else if (run_q && tick) begin
            if (!phase_q) begin
                phase_q <= 1'b1;
            end else if (bit_q == LAST_BIT) begin
                phase_q <= 1'b0;
                run_q   <= 1'b0;
            end else begin
                phase_q <= 1'b0;
                bit_q   <= bit_q + 1'b1;
            end
        end
    end

    // Read capture: shift in the line at each rising edge of a data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (run_q && tick && !phase_q && rd_q && (bit_q >= DATA_FIRST)) begin
            rx_q <= {rx_q[DATA_W-2:0], mdio_i};
        end
    end

    assign running = run_q;
    assign done    = run_q && tick && phase_q && (bit_q == LAST_BIT);
    assign rdata   = rx_q;
    assign mdc     = phase_q;
    assign mdio_o  = run_q && (bit_q[CNT_BITS_W-1] ? hdr_q[~bit_q[4:0]] : 1'b1);
    assign mdio_oe = run_q && !(rd_q && (bit_q >= REL_FIRST));
endmodule

// File: rtl/mdio_host_regs.sv
// Host register file: decodes writes, launches frames, tracks the
// pending-data flag and serves combinational reads.
// Assumes one write per cycle; writes other than an abort are dropped
// while a frame is running.
module mdio_host_regs
    import mdio_pkg::*;
#(
    parameter logic [SEL_W-1:0] INIT_SEL = 3'd7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_en,
    input  logic [HOST_AW-1:0] bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               busy,
    input  logic               done,
    input  logic [DATA_W-1:0]  rx_data,
    output logic [SEL_W-1:0]   sel,
    output target_t            tgt,
    output logic               start,
    output logic               start_rd,
    output logic               abort,
    output logic               pending
);
    logic [WIDX_W-1:0] widx;
    logic              wr_setup, wr_rdreq, wr_tgt, wr_dout;
    logic              rdreq_q;
    logic [DATA_W-1:0] dout_q;
    logic [DATA_W-1:0] din_q;

    // Word decode and launch conditions.
    always_comb begin
        widx     = bus_addr[HOST_AW-1:2];
        wr_setup = bus_wr_en && (widx == W_SETUP);
        wr_rdreq = bus_wr_en && (widx == W_RDREQ);
        wr_tgt   = bus_wr_en && (widx == W_TARGET);
        wr_dout  = bus_wr_en && (widx == W_DOUT);
        abort    = wr_setup && bus_wdata[31];
        start_rd = wr_rdreq && bus_wdata[0] && !rdreq_q && !busy;
        start    = start_rd || (wr_dout && !busy);
    end

    // Register state: updates when idle, full clear on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel     <= INIT_SEL;
            rdreq_q <= 1'b0;
            tgt     <= '0;
            dout_q  <= '0;
            din_q   <= '0;
            pending <= 1'b0;
        end else if (abort) begin
            sel     <= bus_wdata[SEL_W-1:0];
            rdreq_q <= 1'b0;
            tgt     <= '0;
            dout_q  <= '0;
            din_q   <= '0;
            pending <= 1'b0;
        end else begin
            if (wr_setup && !busy) sel     <= bus_wdata[SEL_W-1:0];
            if (wr_rdreq && !busy) rdreq_q <= bus_wdata[0];
            if (wr_tgt && !busy) begin
                tgt.phy  <= bus_wdata[12:8];
                tgt.regn <= bus_wdata[4:0];
            end
            if (wr_dout && !busy) dout_q <= bus_wdata[DATA_W-1:0];
            if (start_rd) begin
                pending <= 1'b1;
            end else if (done && pending) begin
                pending <= 1'b0;
                din_q   <= rx_data;
            end
        end
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        unique case (widx)
            W_SETUP:  bus_rdata[SEL_W-1:0]  = sel;
            W_RDREQ:  bus_rdata[0]          = rdreq_q;
            W_TARGET: begin
                bus_rdata[12:8] = tgt.phy;
                bus_rdata[4:0]  = tgt.regn;
            end
            W_DOUT:   bus_rdata[DATA_W-1:0] = dout_q;
            W_DIN:    bus_rdata[DATA_W-1:0] = din_q;
            W_STAT:   bus_rdata[2:0]        = {pending, 1'b0, busy};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
// Top: management-bus master. Joins the host registers, the half-period
// timer and the frame engine. Assumes an external pull-up on the line.
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int unsigned      DIV_MIN_HALF = 10,
    parameter int unsigned      DIV_STEP     = 2,
    parameter logic [SEL_W-1:0] INIT_SEL     = 3'd7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_en,
    input  logic [HOST_AW-1:0] bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               mdc,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe
);
    logic              eng_running, eng_done, tick;
    logic              go, go_rd, abort, rd_pending;
    logic [SEL_W-1:0]  div_sel;
    target_t           tgt;
    logic [DATA_W-1:0] rx_data;

    mdio_host_regs #(.INIT_SEL(INIT_SEL)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(eng_running),
        .done(eng_done), .rx_data(rx_data), .sel(div_sel), .tgt(tgt),
        .start(go), .start_rd(go_rd), .abort(abort), .pending(rd_pending)
    );

    mdio_clk_div #(.SEL_W(SEL_W), .MIN_HALF(DIV_MIN_HALF), .STEP(DIV_STEP)) u_div (
        .clk(clk), .rst_n(rst_n), .run(eng_running), .sel(div_sel), .tick(tick)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(go), .start_rd(go_rd), .abort(abort),
        .tgt(tgt), .wdata(bus_wdata[DATA_W-1:0]), .tick(tick), .mdio_i(mdio_i),
        .running(eng_running), .done(eng_done), .rdata(rx_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
// Checker: temporal properties of the management master, bound to the top.
module mdio_mgmt_master_chk
    import mdio_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr_en,
    input logic [HOST_AW-1:0] bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               busy,
    input logic               pending,
    input logic               mdc,
    input logic               mdio_oe,
    input logic [9:0]         tgt_bits
);
    logic [WIDX_W-1:0] widx;
    assign widx = bus_addr[HOST_AW-1:2];

    AST_DOUT_LAUNCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && widx == W_DOUT && !busy) |=> busy);  // R6

    AST_PENDING_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> busy);  // R7

    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));  // R11

    AST_TARGET_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr_en && widx == W_TARGET) |=> $stable(tgt_bits));  // R9

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && widx == W_SETUP && bus_wdata[31]) |=>
        (!busy && !pending && !mdc && !mdio_oe));  // R10
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk i_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(eng_running), .pending(rd_pending),
    .mdc(mdc), .mdio_oe(mdio_oe), .tgt_bits({tgt.phy, tgt.regn})
);

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
    localparam logic [4:0] A_SETUP = 5'h00, A_RDREQ = 5'h04, A_TGT = 5'h08,
                           A_DOUT = 5'h0C, A_DIN = 5'h10, A_STAT = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [4:0]  bus_addr = 5'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    integer checks = 0;
    integer errors = 0;
    integer cyc = 0;
    integer mdc_bits = 0;
    logic [63:0] cap = '0;
    logic [63:0] oe_cap = '0;
    logic [15:0] phy_reply = '0;

    mdio_mgmt_master i_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // PHY model: record the line and the drive enable at each rising edge.
    always @(posedge mdc) begin
        #1;
        cap      = {cap[62:0], (mdio_oe ? mdio_o : mdio_i)};
        oe_cap   = {oe_cap[62:0], mdio_oe};
        mdc_bits = mdc_bits + 1;
    end

    // PHY model: drive the next read-data bit after each falling edge.
    always @(negedge mdc) begin
        if (mdc_bits >= 48 && mdc_bits <= 63) mdio_i = phy_reply[63 - mdc_bits];
        else mdio_i = 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Busy must hold through cycle t0+128h-1 and drop at t0+128h.
    task automatic wait_done(input integer t0, input integer h, input string req);
        bus_addr = A_STAT;
        while (cyc < t0 + 128 * h - 1) @(negedge clk);
        #1 chk({req, " busy held"}, 64'(bus_rdata[0]), 64'd1);
        @(negedge clk);
        #1 chk({req, " busy cleared"}, 64'(bus_rdata[0]), 64'd0);
        chk("R11 mdc low after frame", 64'(mdc), 64'd0);
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] rn,
                            input logic [15:0] d, input integer h);
        integer t0;
        mdc_bits = 0;
        bus_write(A_TGT, {19'd0, phy, 3'd0, rn});
        bus_write(A_DOUT, {16'hA5A5, d});
        t0 = cyc;
        wait_done(t0, h, "R6 R8 write");
        chk("R3 write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rn, 2'b10, d});
        chk("R11 rises per frame", 64'(mdc_bits), 64'd64);
        chk("R3 drive enable", oe_cap, {64{1'b1}});
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] rn,
                           input logic [15:0] reply, input integer h);
        integer t0;
        logic [31:0] d;
        phy_reply = reply;
        mdc_bits = 0;
        bus_write(A_TGT, {19'd0, phy, 3'd0, rn});
        bus_write(A_RDREQ, 32'd0);
        bus_write(A_RDREQ, 32'd1);
        t0 = cyc;
        bus_addr = A_STAT;
        #1 chk("R7 pending and busy at launch", 64'(bus_rdata), 64'h5);
        wait_done(t0, h, "R6 read");
        bus_read(A_DIN, d);
        chk("R5 read data", 64'(d), 64'(reply));
        bus_read(A_STAT, d);
        chk("R7 pending cleared", 64'(d), 64'h0);
        chk("R5 read frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rn, 2'b11, reply});
        chk("R5 line released", oe_cap, {{46{1'b1}}, {18{1'b0}}});
    endtask

    initial begin
        #(20 * 190000);
        errors = errors + 1;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(A_SETUP, d); chk("R1 setup", 64'(d), 64'd7);
        bus_read(A_STAT, d);  chk("R1 status", 64'(d), 64'd0);
        bus_read(A_DIN, d);   chk("R1 read data", 64'(d), 64'd0);
        bus_read(A_TGT, d);   chk("R1 target", 64'(d), 64'd0);
        chk("R1 mdc", 64'(mdc), 64'd0);
        chk("R1 oe", 64'(mdio_oe), 64'd0);

        // R2 target fields
        bus_write(A_TGT, 32'hFFFF_FFFF);
        bus_read(A_TGT, d); chk("R2 target fields", 64'(d), 64'h1F1F);

        // R8 divider sweep with write frames (R3)
        do_write(5'h1F, 5'h00, 16'hFFFF, 24);
        bus_write(A_SETUP, 32'd0);
        do_write(5'h00, 5'h1F, 16'h0000, 10);
        do_write(5'h15, 5'h0A, 16'h8001, 10);
        bus_write(A_SETUP, 32'd1);
        do_write(5'h0A, 5'h15, 16'h1234, 12);
        bus_write(A_SETUP, 32'd3);
        do_write(5'h11, 5'h03, 16'hBEEF, 16);

        // R5 reads, R7 pending flag
        bus_write(A_SETUP, 32'd0);
        do_read(5'h01, 5'h02, 16'hC3A5, 10);
        do_read(5'h1E, 5'h11, 16'h0001, 10);
        do_read(5'h07, 5'h1C, 16'h8000, 10);

        // R4 no launch without a 0-to-1 edge
        mdc_bits = 0;
        bus_write(A_RDREQ, 32'd1);
        repeat (50) @(negedge clk);
        bus_addr = A_STAT;
        #1 chk("R4 no frame on held bit", 64'(bus_rdata), 64'd0);
        chk("R4 no clock edges", 64'(mdc_bits), 64'd0);

        // R9 writes while busy are ignored
        begin
            integer t0;
            mdc_bits = 0;
            bus_write(A_TGT, {19'd0, 5'h0C, 3'd0, 5'h06});
            bus_write(A_DOUT, 32'h0000_5A3C);
            t0 = cyc;
            repeat (100) @(negedge clk);
            bus_write(A_TGT, 32'h0000_1F1F);
            bus_write(A_DOUT, 32'h0000_FFFF);
            bus_write(A_RDREQ, 32'd0);
            bus_write(A_SETUP, 32'd5);
            wait_done(t0, 10, "R9 frame not restarted");
            chk("R9 frame unaltered", cap, {32'hFFFF_FFFF, 4'b0101, 5'h0C, 5'h06, 2'b10, 16'h5A3C});
            bus_read(A_TGT, d);   chk("R9 target held", 64'(d), 64'h0C06);
            bus_read(A_DOUT, d);  chk("R9 data out held", 64'(d), 64'h5A3C);
            bus_read(A_RDREQ, d); chk("R9 read request held", 64'(d), 64'd1);
            bus_read(A_SETUP, d); chk("R9 setup held", 64'(d), 64'd0);
        end

        // R10 abort mid-frame
        bus_write(A_DOUT, 32'h0000_1111);
        repeat (300) @(negedge clk);
        bus_write(A_SETUP, 32'h8000_0002);
        bus_addr = A_STAT;
        #1 chk("R10 status cleared", 64'(bus_rdata), 64'd0);
        chk("R10 mdc low", 64'(mdc), 64'd0);
        chk("R10 line released", 64'(mdio_oe), 64'd0);
        bus_read(A_SETUP, d); chk("R10 setup taken", 64'(d), 64'd2);
        bus_read(A_TGT, d);   chk("R10 target cleared", 64'(d), 64'd0);
        bus_read(A_DOUT, d);  chk("R10 data out cleared", 64'(d), 64'd0);
        bus_read(A_RDREQ, d); chk("R10 request cleared", 64'(d), 64'd0);
        bus_read(A_DIN, d);   chk("R10 read data cleared", 64'(d), 64'd0);
        repeat (40) @(negedge clk);
        chk("R11 idle after abort", 64'(mdc), 64'd0);

        // R8 divider after abort, then a read at the new rate
        do_write(5'h03, 5'h18, 16'h7E81, 14);
        do_read(5'h12, 5'h09, 16'h5AA5, 14);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule